// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the finite-state controller of a small 8-bit multicycle processor. It reads the 6-bit opcode field and the 6-bit function field of the current instruction. From these it produces every datapath control on every clock: memory read and write strobes, the address source, the instruction-register byte enables, the PC write and conditional write, the PC source, the ALU operand selects, the ALU operation class, the register-file destination select and the register write enable. It also turns the ALU operation class and the function field into a 3-bit ALU operation code.

Memory is eight bits wide, so a 32-bit instruction arrives as four bytes in four consecutive fetch states. A decode state follows, and then one execution path for each instruction class. Ten instructions are supported: register add, subtract, and, or and set-less-than; immediate add; branch on equal; jump; byte load; and byte store. The immediate add has execute and write-back states of its own. Every path ends by returning to the first fetch state. All controls come straight from flops, so each output is valid for the whole of its state.

Top module: `mc_seq_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in fetch byte 0, and the outputs show fetch byte 0 controls on the clock after reset is sampled, including a reset that arrives in the middle of an instruction.
- R2: Fetch lasts FETCH_BYTES (default 4) states. Each fetch state drives mem_rd=1, pc_wr=1, pc_src=00, alu_src_a=0 (PC), alu_src_b=01 (constant one), alu_op=00 and iord=0. ir_wr is 0001, 0010, 0100 and 1000 in order, and no other opcode input affects this sequence.
- R3: After the last fetch byte comes one decode state with alu_src_a=0, alu_src_b=10 (immediate) and alu_op=00, and with every enable and strobe low. The opcode input (instruction bits [31:26]) is sampled here to pick the path.
- R4: Opcode 100000 (byte load) runs three states. The address state has alu_src_a=1, alu_src_b=10 and alu_op=00. The read state has mem_rd=1 and iord=1. The write-back state has reg_wr=1, mem_to_reg=1 and reg_dst=0. Fetch byte 0 follows.
- R5: Opcode 101000 (byte store) runs the same address state, then a write state with mem_wr=1 and iord=1, then fetch byte 0.
- R6: Opcode 000000 (register type) runs an execute state with alu_src_a=1, alu_src_b=00 and alu_op=10. A write-back state follows with reg_wr=1, reg_dst=1 (bits [15:11]) and mem_to_reg=0.
- R7: Opcode 001000 (immediate add) runs an execute state with alu_src_a=1, alu_src_b=10 and alu_op=00. A write-back state follows with reg_wr=1, reg_dst=0 (bits [20:16]) and mem_to_reg=0.
- R8: Opcode 000100 (branch on equal) runs one state with alu_src_a=1, alu_src_b=00, alu_op=01, pc_wr_cond=1, pc_wr=0 and pc_src=01. Fetch byte 0 follows.
- R9: Opcode 000010 (jump) runs one state with pc_wr=1 and pc_src=10. Fetch byte 0 follows.
- R10: Any other opcode seen in decode sends the sequencer straight back to fetch byte 0.
- R11: alu_ctl is 010 (add) for alu_op=00 and 110 (subtract) for alu_op=01. For alu_op=10 it follows the function field: 100000 gives 010, 100010 gives 110, 100100 gives 000 (and), 100101 gives 001 (or), 101010 gives 111 (set-less-than), and any other value gives 010.
- R12: In every state, a control not named for that state in R2 to R9 is 0, so mem_rd and mem_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Instruction bits [31:26] |
| funct | input | 6 | Instruction bits [5:0] |
| iord | output | 1 | Memory address from ALU output register (1) or PC (0) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_to_reg | output | 1 | Register write data from memory data register |
| ir_wr | output | FETCH_BYTES | Instruction-register byte write enables |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write when ALU result is zero |
| pc_src | output | 2 | PC source: 00 ALU result, 01 ALU output register, 10 jump target |
| alu_op | output | 2 | ALU operation class |
| alu_src_a | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_src_b | output | 2 | ALU B operand: 00 register B, 01 constant one, 10 immediate |
| reg_dst | output | 1 | Destination register field: 1 bits [15:11], 0 bits [20:16] |
| reg_wr | output | 1 | Register file write enable |
| alu_ctl | output | 3 | ALU operation code |

## Verification
The bench runs a program that holds every instruction class, plus two unrecognised opcodes. Random opcode and function values are driven during fetch, which shows that the fetch sequence does not depend on them. The register-type instructions cover every listed function code and one unlisted code, which separates the five ALU operations from the add fallback. The byte load and byte store share an address state, and only the opcode sampled there tells their paths apart. A reset injected during the byte-load read state checks that the sequencer recovers in the middle of an instruction.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  typedef enum logic [3:0] {
    PH_FETCH,
    PH_DECODE,
    PH_MADDR,
    PH_MREAD,
    PH_MLOAD,
    PH_MSTORE,
    PH_REXEC,
    PH_RWB,
    PH_IEXEC,
    PH_IWB,
    PH_BRANCH,
    PH_JUMP
  } phase_e;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'b001000;
  localparam logic [OPC_W-1:0] OPC_LB    = 6'b100000;
  localparam logic [OPC_W-1:0] OPC_SB    = 6'b101000;

  localparam logic [1:0] AOP_ADD   = 2'b00;
  localparam logic [1:0] AOP_SUB   = 2'b01;
  localparam logic [1:0] AOP_FUNCT = 2'b10;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

  localparam logic [2:0] ALU_AND = 3'b000;
  localparam logic [2:0] ALU_OR  = 3'b001;
  localparam logic [2:0] ALU_ADD = 3'b010;
  localparam logic [2:0] ALU_SUB = 3'b110;
  localparam logic [2:0] ALU_SLT = 3'b111;

  localparam logic [1:0] SRCB_REG = 2'b00;
  localparam logic [1:0] SRCB_ONE = 2'b01;
  localparam logic [1:0] SRCB_IMM = 2'b10;

  localparam logic [1:0] PCS_ALU  = 2'b00;
  localparam logic [1:0] PCS_AOUT = 2'b01;
  localparam logic [1:0] PCS_JUMP = 2'b10;

  typedef struct packed {
    logic       iord;
    logic       mem_rd;
    logic       mem_wr;
    logic       mem_to_reg;
    logic       pc_wr;
    logic       pc_wr_cond;
    logic [1:0] pc_src;
    logic [1:0] alu_op;
    logic       alu_src_a;
    logic [1:0] alu_src_b;
    logic       reg_dst;
    logic       reg_wr;
  } ctl_t;

endpackage

// File: rtl/mcs_next_state.sv
module mcs_next_state
  import mcs_pkg::*;
#(
  parameter int FETCH_BYTES = 4,
  parameter int IDX_W       = 2
) (
  input  phase_e           ph_q,
  input  logic [IDX_W-1:0] idx_q,
  input  logic [OPC_W-1:0] opcode,
  output phase_e           ph_d,
  output logic [IDX_W-1:0] idx_d
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FETCH_BYTES - 1);

  always_comb begin
    ph_d  = PH_FETCH;
    idx_d = '0;
    unique case (ph_q)
      PH_FETCH: begin
        if (idx_q == IDX_LAST) begin
          ph_d = PH_DECODE;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      PH_DECODE: begin
        unique case (opcode)
          OPC_RTYPE:      ph_d = PH_REXEC;
          OPC_LB, OPC_SB: ph_d = PH_MADDR;
          OPC_BEQ:        ph_d = PH_BRANCH;
          OPC_JUMP:       ph_d = PH_JUMP;
          OPC_ADDI:       ph_d = PH_IEXEC;
          default:        ph_d = PH_FETCH;
        endcase
      end
      PH_MADDR: begin
        if (opcode == OPC_LB)      ph_d = PH_MREAD;
        else if (opcode == OPC_SB) ph_d = PH_MSTORE;
        else                       ph_d = PH_FETCH;
      end
      PH_MREAD: ph_d = PH_MLOAD;
      PH_REXEC: ph_d = PH_RWB;
      PH_IEXEC: ph_d = PH_IWB;
      default:  ph_d = PH_FETCH;
    endcase
  end

endmodule

// File: rtl/mcs_ctl_decode.sv
module mcs_ctl_decode
  import mcs_pkg::*;
#(
  parameter int FETCH_BYTES = 4,
  parameter int IDX_W       = 2
) (
  input  phase_e                 ph,
  input  logic [IDX_W-1:0]       idx,
  output ctl_t                   ctl,
  output logic [FETCH_BYTES-1:0] ir_wr
);

  for (genvar g = 0; g < FETCH_BYTES; g++) begin : g_irwr
    assign ir_wr[g] = (ph == PH_FETCH) && (idx == IDX_W'(g));
  end

  always_comb begin
    ctl = '0;
    unique case (ph)
      PH_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.pc_wr     = 1'b1;
        ctl.pc_src    = PCS_ALU;
        ctl.alu_src_b = SRCB_ONE;
        ctl.alu_op    = AOP_ADD;
      end
      PH_DECODE: begin
        ctl.alu_src_b = SRCB_IMM;
        ctl.alu_op    = AOP_ADD;
      end
      PH_MADDR, PH_IEXEC: begin
        ctl.alu_src_a = 1'b1;
        ctl.alu_src_b = SRCB_IMM;
        ctl.alu_op    = AOP_ADD;
      end
      PH_MREAD: begin
        ctl.mem_rd = 1'b1;
        ctl.iord   = 1'b1;
      end
      PH_MLOAD: begin
        ctl.reg_wr     = 1'b1;
        ctl.mem_to_reg = 1'b1;
      end
      PH_MSTORE: begin
        ctl.mem_wr = 1'b1;
        ctl.iord   = 1'b1;
      end
      PH_REXEC: begin
        ctl.alu_src_a = 1'b1;
        ctl.alu_src_b = SRCB_REG;
        ctl.alu_op    = AOP_FUNCT;
      end
      PH_RWB: begin
        ctl.reg_wr  = 1'b1;
        ctl.reg_dst = 1'b1;
      end
      PH_IWB: begin
        ctl.reg_wr = 1'b1;
      end
      PH_BRANCH: begin
        ctl.alu_src_a  = 1'b1;
        ctl.alu_src_b  = SRCB_REG;
        ctl.alu_op     = AOP_SUB;
        ctl.pc_wr_cond = 1'b1;
        ctl.pc_src     = PCS_AOUT;
      end
      PH_JUMP: begin
        ctl.pc_wr  = 1'b1;
        ctl.pc_src = PCS_JUMP;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/mcs_alu_decode.sv
module mcs_alu_decode
  import mcs_pkg::*;
(
  input  logic [1:0]      alu_op,
  input  logic [FN_W-1:0] funct,
  output logic [2:0]      alu_ctl
);

  always_comb begin
    unique case (alu_op)
      AOP_ADD: alu_ctl = ALU_ADD;
      AOP_SUB: alu_ctl = ALU_SUB;
      default: begin
        unique case (funct)
          FN_ADD:  alu_ctl = ALU_ADD;
          FN_SUB:  alu_ctl = ALU_SUB;
          FN_AND:  alu_ctl = ALU_AND;
          FN_OR:   alu_ctl = ALU_OR;
          FN_SLT:  alu_ctl = ALU_SLT;
          default: alu_ctl = ALU_ADD;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
  import mcs_pkg::*;
#(
  parameter int FETCH_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [5:0]             opcode,
  input  logic [5:0]             funct,
  output logic                   iord,
  output logic                   mem_rd,
  output logic                   mem_wr,
  output logic                   mem_to_reg,
  output logic [FETCH_BYTES-1:0] ir_wr,
  output logic                   pc_wr,
  output logic                   pc_wr_cond,
  output logic [1:0]             pc_src,
  output logic [1:0]             alu_op,
  output logic                   alu_src_a,
  output logic [1:0]             alu_src_b,
  output logic                   reg_dst,
  output logic                   reg_wr,
  output logic [2:0]             alu_ctl
);

  localparam int IDX_W = (FETCH_BYTES > 1) ? $clog2(FETCH_BYTES) : 1;

  phase_e                 ph_q, ph_d, ph_n;
  logic [IDX_W-1:0]       idx_q, idx_d, idx_n;
  ctl_t                   ctl_n, ctl_q;
  logic [FETCH_BYTES-1:0] irw_n, irw_q;

  mcs_next_state #(.FETCH_BYTES(FETCH_BYTES), .IDX_W(IDX_W)) u_next (
    .ph_q   (ph_q),
    .idx_q  (idx_q),
    .opcode (opcode),
    .ph_d   (ph_d),
    .idx_d  (idx_d)
  );

  // reset overrides the step so the output decode sees the same target state
  always_comb begin
    ph_n  = rst ? PH_FETCH : ph_d;
    idx_n = rst ? '0 : idx_d;
  end

  mcs_ctl_decode #(.FETCH_BYTES(FETCH_BYTES), .IDX_W(IDX_W)) u_dec (
    .ph    (ph_n),
    .idx   (idx_n),
    .ctl   (ctl_n),
    .ir_wr (irw_n)
  );

  always_ff @(posedge clk) begin
    ph_q  <= ph_n;
    idx_q <= idx_n;
    ctl_q <= ctl_n;
    irw_q <= irw_n;
  end

  mcs_alu_decode u_alu (
    .alu_op  (ctl_q.alu_op),
    .funct   (funct),
    .alu_ctl (alu_ctl)
  );

  assign iord       = ctl_q.iord;
  assign mem_rd     = ctl_q.mem_rd;
  assign mem_wr     = ctl_q.mem_wr;
  assign mem_to_reg = ctl_q.mem_to_reg;
  assign ir_wr      = irw_q;
  assign pc_wr      = ctl_q.pc_wr;
  assign pc_wr_cond = ctl_q.pc_wr_cond;
  assign pc_src     = ctl_q.pc_src;
  assign alu_op     = ctl_q.alu_op;
  assign alu_src_a  = ctl_q.alu_src_a;
  assign alu_src_b  = ctl_q.alu_src_b;
  assign reg_dst    = ctl_q.reg_dst;
  assign reg_wr     = ctl_q.reg_wr;

endmodule

// File: rtl/mcs_seq_checker.sv
module mcs_seq_checker #(
  parameter int FETCH_BYTES = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   iord,
  input logic                   mem_rd,
  input logic                   mem_wr,
  input logic                   mem_to_reg,
  input logic [FETCH_BYTES-1:0] ir_wr,
  input logic                   pc_wr,
  input logic                   pc_wr_cond,
  input logic [1:0]             pc_src,
  input logic [1:0]             alu_op,
  input logic [1:0]             alu_src_b,
  input logic                   reg_wr,
  input logic [2:0]             alu_ctl
);

  a_r1_reset_to_fetch: assert property (@(posedge clk)
    rst |=> (ir_wr[0] && mem_rd && !mem_wr));

  a_r2_irwr_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ir_wr));

  a_r2_fetch_controls: assert property (@(posedge clk) disable iff (rst)
    (ir_wr != '0) |-> (mem_rd && pc_wr && !iord && alu_src_b == 2'b01));

  a_r2_fetch_order: assert property (@(posedge clk) disable iff (rst)
    ((ir_wr != '0) && !ir_wr[FETCH_BYTES-1]) |=> (ir_wr == ($past(ir_wr) << 1)));

  a_r3_decode_follows: assert property (@(posedge clk) disable iff (rst)
    ir_wr[FETCH_BYTES-1] |=> (ir_wr == '0 && !mem_rd && !mem_wr && !reg_wr
                              && !pc_wr && alu_src_b == 2'b10));

  a_r4_load_writeback: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && iord) |=> (reg_wr && mem_to_reg));

  a_r5_store_returns: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> ir_wr[0]);

  a_r8_branch_controls: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |-> (alu_op == 2'b01 && !pc_wr && pc_src == 2'b01));

  a_r11_sub_class: assert property (@(posedge clk) disable iff (rst)
    (alu_op == 2'b01) |-> (alu_ctl == 3'b110));

  a_r12_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

endmodule

bind mc_seq_ctrl mcs_seq_checker #(.FETCH_BYTES(FETCH_BYTES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .iord       (iord),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_to_reg (mem_to_reg),
  .ir_wr      (ir_wr),
  .pc_wr      (pc_wr),
  .pc_wr_cond (pc_wr_cond),
  .pc_src     (pc_src),
  .alu_op     (alu_op),
  .alu_src_b  (alu_src_b),
  .reg_wr     (reg_wr),
  .alu_ctl    (alu_ctl)
);

// File: tb/mc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mc_seq_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = '0;
  logic [5:0] funct = '0;
  logic       iord, mem_rd, mem_wr, mem_to_reg, pc_wr, pc_wr_cond;
  logic       alu_src_a, reg_dst, reg_wr;
  logic [3:0] ir_wr;
  logic [1:0] pc_src, alu_op, alu_src_b;
  logic [2:0] alu_ctl;

  always #2 clk = ~clk;

  mc_seq_ctrl #(.FETCH_BYTES(4)) dut_i (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct),
    .iord(iord), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_to_reg(mem_to_reg),
    .ir_wr(ir_wr), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src),
    .alu_op(alu_op), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b),
    .reg_dst(reg_dst), .reg_wr(reg_wr), .alu_ctl(alu_ctl)
  );

  int errors = 0;
  int checks = 0;
  int ph = 0;          // model state: 0..3 fetch, 4 dec, 5 addr, 6 read, 7 load wb,
                       // 8 store, 9 r exec, 10 r wb, 11 beq, 12 jump, 13 i exec, 14 i wb
  string pend_tag = "R1";
  logic [12:0] prog[$];   // {reset-during-read marker, opcode, funct}
  logic [12:0] cur;

  // vector: iord mem_rd mem_wr mem_to_reg ir_wr[3:0] pc_wr pc_wr_cond pc_src alu_op src_a src_b reg_dst reg_wr
  function automatic logic [18:0] exp_ctl(int p);
    logic io = 0, mr = 0, mw = 0, m2r = 0, pw = 0, pwc = 0, sa = 0, rd = 0, rw = 0;
    logic [3:0] irw = 0;
    logic [1:0] ps = 0, op = 0, sb = 0;
    if (p < 4) begin mr = 1; irw = 4'b0001 << p; pw = 1; sb = 2'b01; end
    else case (p)
      4:  sb = 2'b10;
      5, 13: begin sa = 1; sb = 2'b10; end
      6:  begin mr = 1; io = 1; end
      7:  begin rw = 1; m2r = 1; end
      8:  begin mw = 1; io = 1; end
      9:  begin sa = 1; op = 2'b10; end
      10: begin rw = 1; rd = 1; end
      11: begin sa = 1; op = 2'b01; pwc = 1; ps = 2'b01; end
      12: begin pw = 1; ps = 2'b10; end
      14: rw = 1;
      default: ;
    endcase
    return {io, mr, mw, m2r, irw, pw, pwc, ps, op, sa, sb, rd, rw};
  endfunction

  function automatic logic [2:0] exp_alu(logic [1:0] op, logic [5:0] fn);
    if (op == 2'b00) return 3'b010;
    if (op == 2'b01) return 3'b110;
    case (fn)
      6'b100000: return 3'b010;
      6'b100010: return 3'b110;
      6'b100100: return 3'b000;
      6'b100101: return 3'b001;
      6'b101010: return 3'b111;
      default:   return 3'b010;
    endcase
  endfunction

  function automatic string tag_of(int p);
    if (p < 4) return "R2";
    case (p)
      4: return "R3";
      5, 6, 7: return "R4";
      8: return "R5";
      9, 10: return "R6";
      11: return "R8";
      12: return "R9";
      default: return "R7";
    endcase
  endfunction

  function automatic int next_ph(int p, logic [5:0] opc);
    if (p < 4) return p + 1;
    case (p)
      4: case (opc)
           6'b000000: return 9;
           6'b100000, 6'b101000: return 5;
           6'b000100: return 11;
           6'b000010: return 12;
           6'b001000: return 13;
           default: return 0;
         endcase
      5: return (opc == 6'b100000) ? 6 : ((opc == 6'b101000) ? 8 : 0);
      6: return 7;
      9: return 10;
      13: return 14;
      default: return 0;
    endcase
  endfunction

  task automatic cycle();
    logic [18:0] act, exp;
    logic [2:0] ea;
    string t;
    @(negedge clk);
    t = (pend_tag != "") ? pend_tag : tag_of(ph);
    act = {iord, mem_rd, mem_wr, mem_to_reg, ir_wr, pc_wr, pc_wr_cond, pc_src,
           alu_op, alu_src_a, alu_src_b, reg_dst, reg_wr};
    exp = exp_ctl(ph);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s state=%0d controls actual=%b expected=%b", t, ph, act, exp);
    end
    ea = exp_alu(exp[6:5], funct);
    checks++;
    if (alu_ctl !== ea) begin
      errors++;
      $display("FAIL R11 state=%0d alu_ctl actual=%b expected=%b", ph, alu_ctl, ea);
    end
    checks++;   // R12: strobes never together
    if (mem_rd && mem_wr) begin
      errors++;
      $display("FAIL R12 strobes actual=11 expected=not both");
    end
    pend_tag = "";
    rst = 1'b0;
    if (ph < 4) begin
      opcode = 6'($urandom);
      funct  = 6'($urandom);
    end else begin
      opcode = cur[11:6];
      funct  = cur[5:0];
    end
    if (cur[12] && ph == 6) begin
      rst = 1'b1;
      ph = 0;
      pend_tag = "R1";
    end else begin
      if (ph == 4 && next_ph(4, opcode) == 0) pend_tag = "R10";
      ph = next_ph(ph, opcode);
    end
  endtask

  initial begin
    prog.push_back({1'b0, 6'b000000, 6'b100000});
    prog.push_back({1'b0, 6'b000000, 6'b100010});
    prog.push_back({1'b0, 6'b000000, 6'b100100});
    prog.push_back({1'b0, 6'b000000, 6'b100101});
    prog.push_back({1'b0, 6'b000000, 6'b101010});
    prog.push_back({1'b0, 6'b000000, 6'b000111});
    prog.push_back({1'b0, 6'b001000, 6'b101010});
    prog.push_back({1'b0, 6'b100000, 6'b000000});
    prog.push_back({1'b0, 6'b101000, 6'b100100});
    prog.push_back({1'b0, 6'b000100, 6'b100101});
    prog.push_back({1'b0, 6'b000010, 6'b000000});
    prog.push_back({1'b0, 6'b111111, 6'b000000});
    prog.push_back({1'b0, 6'b000001, 6'b100010});
    prog.push_back({1'b1, 6'b100000, 6'b000000});
    prog.push_back({1'b0, 6'b001000, 6'b000000});
    prog.push_back({1'b0, 6'b101000, 6'b000000});
    prog.push_back({1'b0, 6'b000100, 6'b000000});
    rst = 1'b1;
    repeat (3) @(posedge clk);
    while (prog.size() > 0) begin
      cur = prog.pop_front();
      do cycle(); while (ph != 0);
    end
    cur = '0;
    cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule